// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Light Controller

This block sequences the signal lamps at a crossing where a heavily used highway meets a rarely used farm road. The highway is green by default. A car sensor on the farm road asks for the right of way. The controller passes through four phases: highway green, highway yellow, farm green and farm yellow. Each phase shows red to the cross road.

All timing comes from one internal interval counter. The counter restarts on every phase change. It raises a short-expired flag, which paces the yellow phases, and a long-expired flag, which paces the green phases. Both thresholds are parameters, counted in clock cycles.

Phase durations below count rising clock edges. The count starts at the edge that enters a phase, or at the first edge after reset is released, and ends at the edge that leaves the phase. SHORT is the short threshold, LONG is the long threshold, and SHORT ≤ LONG is assumed.

Top module: `tlc_crossing`

## Requirements
- R1: While `rst` is high, and on release, the lamps show highway green and farm red, and the interval counter starts from zero.
- R2: Lamp encoding per phase. Highway green shows {hwy_grn, farm_red}. Highway yellow shows {hwy_yel, farm_red}. Farm green shows {farm_grn, hwy_red}. Farm yellow shows {farm_yel, hwy_red}. All other lamps are off.
- R3: While `car` is low, highway green is held with no time limit.
- R4: Highway green ends only when `car` is high and the long flag is set. It therefore lasts at least LONG+1 cycles. If the long flag is already set when a car arrives, highway green ends at the next edge.
- R5: Highway yellow lasts exactly SHORT+1 cycles, whatever `car` does, and then farm green starts.
- R6: Farm green ends at the first edge where `car` is low or the long flag is set. With a car held present it lasts LONG+1 cycles.
- R7: Farm yellow lasts exactly SHORT+1 cycles and then returns to highway green.
- R8: Every phase change restarts the interval counter. A highway green entered with cars still waiting therefore again lasts LONG+1 cycles.
- R9: Exactly one lamp per road is lit at all times, and at least one road shows red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car | input | 1 | A car is waiting on the farm road |
| hwy_grn | output | 1 | Highway green lamp |
| hwy_yel | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_grn | output | 1 | Farm-road green lamp |
| farm_yel | output | 1 | Farm-road yellow lamp |
| farm_red | output | 1 | Farm-road red lamp |

## Verification
The bench builds the controller with SHORT=3 and LONG=8. With these values every phase length can be measured exactly in a handful of cycles, and the bench can tell a minimum-green wait apart from an immediate exit. The small LONG value lets the counter saturate quickly, so the case of a car arriving after the long flag is already set is easy to reach. A counter that fails to restart between the farm phases and the return to highway green becomes visible as a shortened green.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'd0,
        PH_HWY_WARN  = 2'd1,
        PH_FARM_GO   = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_e;

    typedef struct packed {
        logic grn;
        logic yel;
        logic red;
    } lamp_t;

endpackage

// File: rtl/tlc_span_timer.sv
module tlc_span_timer #(
    parameter int SHORT_CYCLES = 200,
    parameter int LONG_CYCLES  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int CW = $clog2(LONG_CYCLES + 1);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYCLES);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LONG_V) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign short_done = (tmr_q.cnt >= SHORT_V);
    assign long_done  = (tmr_q.cnt >= LONG_V);

    // Flags drop right after a restart (R8)
    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!short_done && !long_done));

    // Long expiry implies short expiry (R5)
    assert_flag_order_R5: assert property (@(posedge clk) disable iff (rst)
        long_done |-> short_done);

endmodule

// File: rtl/tlc_phase_ctrl.sv
module tlc_phase_ctrl
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car,
    input  logic   short_done,
    input  logic   long_done,
    output logic   restart,
    output phase_e phase
);
    typedef struct packed {
        phase_e ph;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        restart = 1'b0;
        unique case (ctl_q.ph)
            PH_HWY_GO: if (car && long_done) begin
                ctl_d.ph = PH_HWY_WARN;
                restart  = 1'b1;
            end
            PH_HWY_WARN: if (short_done) begin
                ctl_d.ph = PH_FARM_GO;
                restart  = 1'b1;
            end
            PH_FARM_GO: if (!car || long_done) begin
                ctl_d.ph = PH_FARM_WARN;
                restart  = 1'b1;
            end
            PH_FARM_WARN: if (short_done) begin
                ctl_d.ph = PH_HWY_GO;
                restart  = 1'b1;
            end
            default: begin
                ctl_d.ph = PH_HWY_GO;
                restart  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.ph <= PH_HWY_GO;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase = ctl_q.ph;

    assert_hold_green_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HWY_GO && !car) |=> phase == PH_HWY_GO);

    assert_min_green_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HWY_GO && !long_done) |=> phase == PH_HWY_GO);

    assert_yellow_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HWY_WARN && !short_done) |=> phase == PH_HWY_WARN);

    assert_farm_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FARM_GO && (!car || long_done)) |=> phase == PH_FARM_WARN);

    assert_farm_yellow_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FARM_WARN && short_done) |=> phase == PH_HWY_GO);

    assert_change_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> $past(restart));

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_e phase,
    output lamp_t  hwy,
    output lamp_t  farm
);
    always_comb begin
        hwy  = '{grn: 1'b0, yel: 1'b0, red: 1'b1};
        farm = '{grn: 1'b0, yel: 1'b0, red: 1'b1};
        unique case (phase)
            PH_HWY_GO:    hwy  = '{grn: 1'b1, yel: 1'b0, red: 1'b0};
            PH_HWY_WARN:  hwy  = '{grn: 1'b0, yel: 1'b1, red: 1'b0};
            PH_FARM_GO:   farm = '{grn: 1'b1, yel: 1'b0, red: 1'b0};
            PH_FARM_WARN: farm = '{grn: 1'b0, yel: 1'b1, red: 1'b0};
            default: ;
        endcase
    end
endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
    import tlc_pkg::*;
#(
    parameter int SHORT_CYCLES = 200,
    parameter int LONG_CYCLES  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic car,
    output logic hwy_grn,
    output logic hwy_yel,
    output logic hwy_red,
    output logic farm_grn,
    output logic farm_yel,
    output logic farm_red
);
    logic   restart;
    logic   short_done;
    logic   long_done;
    phase_e phase;
    lamp_t  hwy_l;
    lamp_t  farm_l;

    tlc_span_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .short_done (short_done),
        .long_done  (long_done)
    );

    tlc_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .car        (car),
        .short_done (short_done),
        .long_done  (long_done),
        .restart    (restart),
        .phase      (phase)
    );

    tlc_lamp_decode u_dec (
        .phase (phase),
        .hwy   (hwy_l),
        .farm  (farm_l)
    );

    assign hwy_grn  = hwy_l.grn;
    assign hwy_yel  = hwy_l.yel;
    assign hwy_red  = hwy_l.red;
    assign farm_grn = farm_l.grn;
    assign farm_yel = farm_l.yel;
    assign farm_red = farm_l.red;

    assert_lamp_safety_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot({hwy_grn, hwy_yel, hwy_red}) && $onehot({farm_grn, farm_yel, farm_red})
        && (hwy_red || farm_red));

    assert_green_pairs_red_R2: assert property (@(posedge clk) disable iff (rst)
        (hwy_grn || hwy_yel) |-> farm_red);

endmodule

// File: tb/tlc_crossing_test.sv
`timescale 1ns/1ps
module tlc_crossing_test;
    localparam int SH = 3;
    localparam int LG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car = 1'b0;
    logic hwy_grn, hwy_yel, hwy_red, farm_grn, farm_yel, farm_red;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tlc_crossing #(.SHORT_CYCLES(SH), .LONG_CYCLES(LG)) uut (
        .clk(clk), .rst(rst), .car(car),
        .hwy_grn(hwy_grn), .hwy_yel(hwy_yel), .hwy_red(hwy_red),
        .farm_grn(farm_grn), .farm_yel(farm_yel), .farm_red(farm_red)
    );

    function automatic logic [5:0] lamps();
        return {hwy_grn, hwy_yel, hwy_red, farm_grn, farm_yel, farm_red};
    endfunction

    localparam logic [5:0] L_HG = 6'b100_001;
    localparam logic [5:0] L_HY = 6'b010_001;
    localparam logic [5:0] L_FG = 6'b001_100;
    localparam logic [5:0] L_FY = 6'b001_010;

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_lamps(string req, logic [5:0] exp);
        checks++;
        if (lamps() !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, lamps(), exp);
        end
    endtask

    // Count edges until the lamp pattern changes (sampled at falling edges)
    task automatic phase_len(output int n);
        logic [5:0] start = lamps();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (lamps() == start && n < 200);
    endtask

    // R9: safety monitor on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (!($onehot({hwy_grn, hwy_yel, hwy_red}) && $onehot({farm_grn, farm_yel, farm_red})
                  && (hwy_red || farm_red))) begin
                failures++;
                $display("FAIL R9 actual=%b expected=one lamp per road, one red", lamps());
            end
        end
    end

    task automatic do_reset(logic car_v);
        rst = 1'b1;
        car = car_v;
        repeat (3) @(negedge clk);
        check_lamps("R1 during reset", L_HG);
        rst = 1'b0;
    endtask

    task automatic t_idle_highway();
        do_reset(1'b0);
        repeat (3 * LG) @(negedge clk);
        check_lamps("R3 idle highway stays green", L_HG);
    endtask

    task automatic t_late_car();
        int n;
        do_reset(1'b0);
        repeat (2 * LG) @(negedge clk);
        car = 1'b1;
        phase_len(n);
        check_val("R4 late car exits at next edge", n, 1);
        check_lamps("R2 highway yellow pattern", L_HY);
    endtask

    task automatic t_full_cycle();
        int n;
        do_reset(1'b1);
        phase_len(n);
        check_val("R4 min highway green", n, LG + 1);
        check_lamps("R2 highway yellow pattern", L_HY);
        phase_len(n);
        check_val("R5 highway yellow length", n, SH + 1);
        check_lamps("R2 farm green pattern", L_FG);
        phase_len(n);
        check_val("R6 farm green with car held", n, LG + 1);
        check_lamps("R2 farm yellow pattern", L_FY);
        phase_len(n);
        check_val("R7 farm yellow length", n, SH + 1);
        check_lamps("R7 returns to highway green", L_HG);
        phase_len(n);
        check_val("R8 green after restart with cars waiting", n, LG + 1);
    endtask

    task automatic t_car_leaves_farm();
        int n;
        do_reset(1'b1);
        phase_len(n);
        phase_len(n);
        check_lamps("R6 farm green entered", L_FG);
        repeat (2) @(negedge clk);
        car = 1'b0;
        phase_len(n);
        check_val("R6 farm green ends on car absence", n, 1);
        phase_len(n);
        check_val("R7 farm yellow length", n, SH + 1);
        repeat (3 * LG) @(negedge clk);
        check_lamps("R3 highway holds with no car", L_HG);
    endtask

    task automatic t_car_gone_in_yellow();
        int n;
        do_reset(1'b1);
        phase_len(n);
        car = 1'b0;
        phase_len(n);
        check_val("R5 yellow unaffected by car", n, SH + 1);
        phase_len(n);
        check_val("R6 farm green one cycle without car", n, 1);
    endtask

    initial begin
        t_idle_highway();
        t_late_car();
        t_full_cycle();
        t_car_leaves_farm();
        t_car_gone_in_yellow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule